// File: doc/BRIEF.md
# Mailbox Task and Status Tracker

This block keeps the task state of a bank of message mailboxes in a bus controller. Software starts a task on one mailbox by writing a two-bit command (disable, transmit or receive). The block then holds a read-only busy bit for that mailbox until a protocol engine reports that the task has ended. The engine reports the end of a task with single-cycle event pulses: transmit done, receive done, error, or release of a pending disable. Each mailbox has a small set of status flags that the engine sets and software clears.

From those flags and three class enables (transmit, receive, error), the block derives a per-mailbox service summary. It reports the lowest-numbered mailbox that needs service and whose interrupt enable is set. It also raises one combined poll flag, and an interrupt qualified by a global enable. A few general flags record engine events that belong to no mailbox; software clears these by writing ones, unlike the mailbox flags. A soft-reset input aborts all activity at once.

Top module: `mbox_tracker`

## Requirements
- R1: After `rst_n` is low at a clock edge, all busy bits, pending bits, mailbox commands, mailbox flags and general flags read 0, `hp_idx` reads all ones (0xF) and `poll_flag` and `irq` read 0.
- R2: A command write to mailbox n uses the encoding 00 disable, 01 transmit, 10 receive, and the reserved value 11 is ignored. A transmit or receive command sets busy[n] and clears pend[n] on the next edge.
- R3: An engine event of kind 0 (transmit done) or kind 1 (receive done) on a busy mailbox has these effects on the next edge. It sets flag bit 0 or bit 1 respectively, and receive done also sets bit 2 when `eng_dlcw` is high. It clears error bits 4:3, busy and pend. Engine events on an idle mailbox or on an index of 15 or more change nothing.
- R4: An engine event of kind 2 (error) on a busy mailbox ORs `eng_err` into flag bits 4:3. The mailbox stays busy, unless a disable is pending, in which case busy and pend clear.
- R5: A disable command to an idle mailbox leaves it idle. To a busy mailbox it sets pend and keeps busy, until a release event (kind 3), a done event or an error ends the task.
- R6: The stored command of a mailbox keeps its last written value after the task ends. Only a new command write changes it.
- R7: A flag write to mailbox n keeps each flag bit where `flag_wdata` is 1 and clears it where it is 0. An engine event that sets a bit in the same cycle wins over the clear.
- R8: summary[n] = (en_tx & bit0) | (en_rx & (bit1 | bit2)) | (en_err & (bit3 | bit4)) of mailbox n's flags.
- R9: `hp_idx` is the lowest n with summary[n] and mb_ie[n] both set, or 0xF when there is none.
- R10: `poll_flag` is high when any mailbox has summary and interrupt enable both set, or when any general flag is set. `irq` = `poll_flag` & `irq_en`.
- R11: General flag bits set on the edge after a `gen_set` pulse. They clear when `gen_clr_we` is high with a 1 in `gen_clr_mask`, and a set in the same cycle wins.
- R12: While `sw_reset` is high at an edge, busy, pend and general flags clear, and all commands, flag writes and engine events of that cycle are ignored. Mailbox flags and stored commands keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_reset | input | 1 | Soft reset: abort all tasks, clear general flags |
| cmd_we | input | 1 | Command write strobe |
| cmd_sel | input | 4 | Mailbox addressed by the command |
| cmd_val | input | 2 | Command code (00 off, 01 tx, 10 rx) |
| flag_we | input | 1 | Mailbox flag write strobe |
| flag_sel | input | 4 | Mailbox addressed by the flag write |
| flag_wdata | input | 5 | Keep mask for flags (0 clears a bit) |
| eng_valid | input | 1 | Engine event pulse |
| eng_sel | input | 4 | Mailbox of the engine event |
| eng_kind | input | 2 | Event kind: 0 tx done, 1 rx done, 2 error, 3 release |
| eng_dlcw | input | 1 | Length warning with rx done |
| eng_err | input | 2 | Error bits with an error event |
| gen_set | input | 2 | General flag set pulses |
| gen_clr_we | input | 1 | General flag clear strobe |
| gen_clr_mask | input | 2 | General flags to clear (1 clears) |
| en_tx | input | 1 | Transmit class enable |
| en_rx | input | 1 | Receive class enable |
| en_err | input | 1 | Error class enable |
| irq_en | input | 1 | Global interrupt enable |
| mb_ie | input | 15 | Per-mailbox interrupt enable |
| rd_sel | input | 4 | Mailbox shown on the readback ports |
| rd_cmd | output | 2 | Stored command of `rd_sel` |
| rd_flags | output | 5 | Flags of `rd_sel` |
| mb_busy | output | 15 | Busy bit per mailbox |
| mb_pend | output | 15 | Pending disable per mailbox |
| mb_summary | output | 15 | Service summary per mailbox |
| hp_idx | output | 4 | Highest-priority mailbox, 0xF when none |
| gen_flags | output | 2 | General flags |
| poll_flag | output | 1 | Combined service flag |
| irq | output | 1 | Qualified interrupt |

## Verification
Several functions can fall on one mailbox in the same cycle. A software flag clear can meet an engine event that sets a flag, and a new command can meet an engine completion. The same holds for a general flag clear and a general set pulse. The stimulus provokes each of these collisions directly, then drives thousands of random cycles with narrow index ranges so that writes and events often land on the same mailbox. A behavioural model in the bench predicts every output, and the outputs are compared against it once per cycle.

// File: rtl/mbox_pkg.sv
// Package mbox_pkg: shared encodings and flag layout of the mailbox tracker.
// Assumes the flag vector layout below is also what software reads back.
package mbox_pkg;
    typedef enum logic [1:0] {
        CMD_OFF = 2'b00,
        CMD_TX  = 2'b01,
        CMD_RX  = 2'b10,
        CMD_RSV = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        EV_TXDONE  = 2'd0,
        EV_RXDONE  = 2'd1,
        EV_ERROR   = 2'd2,
        EV_RELEASE = 2'd3
    } ev_e;

    localparam int FLAG_W    = 5;
    localparam int ERR_W     = 2;
    localparam int FL_TXOK   = 0;
    localparam int FL_RXOK   = 1;
    localparam int FL_DLCW   = 2;
    localparam int FL_ERR_LO = 3;
    localparam int FL_ERR_HI = FL_ERR_LO + ERR_W - 1;
endpackage

// File: rtl/mbox_slot.sv
// Module mbox_slot: state of one mailbox (command, busy, pending disable,
// flags) and its service summary bit.
// Assumes at most one engine event per cycle and that events are only
// meaningful while the mailbox is busy.
module mbox_slot
    import mbox_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int IDX   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_reset,
    input  logic              cmd_we,
    input  logic [IDX_W-1:0]  cmd_sel,
    input  logic [1:0]        cmd_val,
    input  logic              flag_we,
    input  logic [IDX_W-1:0]  flag_sel,
    input  logic [FLAG_W-1:0] flag_wdata,
    input  logic              eng_valid,
    input  logic [IDX_W-1:0]  eng_sel,
    input  logic [1:0]        eng_kind,
    input  logic              eng_dlcw,
    input  logic [ERR_W-1:0]  eng_err,
    input  logic              en_tx,
    input  logic              en_rx,
    input  logic              en_err,
    output logic              busy_q,
    output logic              pend_q,
    output logic [1:0]        cmd_q,
    output logic [FLAG_W-1:0] flags_q,
    output logic              summary
);
    localparam logic [IDX_W-1:0] MY = IDX_W'(IDX);

    logic              cmd_hit, flag_hit, eng_hit, ok_evt;
    logic              busy_n, pend_n;
    logic [FLAG_W-1:0] flags_n;
    cmd_e              cmd_c;
    ev_e               kind_c;

    assign cmd_c    = cmd_e'(cmd_val);
    assign kind_c   = ev_e'(eng_kind);
    assign cmd_hit  = cmd_we && (cmd_sel == MY) && (cmd_c != CMD_RSV);
    assign flag_hit = flag_we && (flag_sel == MY);
    assign eng_hit  = eng_valid && (eng_sel == MY) && busy_q;
    assign ok_evt   = eng_hit && (kind_c == EV_TXDONE || kind_c == EV_RXDONE);

    // Next-state merge: software clear first, engine sets, then new command.
    always_comb begin
        flags_n = flag_hit ? (flags_q & flag_wdata) : flags_q;
        busy_n  = busy_q;
        pend_n  = pend_q;
        if (eng_hit) begin
            unique case (kind_c)
                EV_TXDONE: begin
                    flags_n[FL_TXOK] = 1'b1;
                    flags_n[FL_ERR_HI:FL_ERR_LO] = '0;
                    busy_n = 1'b0;
                    pend_n = 1'b0;
                end
                EV_RXDONE: begin
                    flags_n[FL_RXOK] = 1'b1;
                    if (eng_dlcw) flags_n[FL_DLCW] = 1'b1;
                    flags_n[FL_ERR_HI:FL_ERR_LO] = '0;
                    busy_n = 1'b0;
                    pend_n = 1'b0;
                end
                EV_ERROR: begin
                    flags_n[FL_ERR_HI:FL_ERR_LO] = flags_q[FL_ERR_HI:FL_ERR_LO] | eng_err;
                    if (flag_hit)
                        flags_n[FL_ERR_HI:FL_ERR_LO] =
                            (flags_q[FL_ERR_HI:FL_ERR_LO] & flag_wdata[FL_ERR_HI:FL_ERR_LO]) | eng_err;
                    if (pend_q) begin
                        busy_n = 1'b0;
                        pend_n = 1'b0;
                    end
                end
                default: begin
                    if (pend_q) begin
                        busy_n = 1'b0;
                        pend_n = 1'b0;
                    end
                end
            endcase
        end
        if (cmd_hit) begin
            if (cmd_c != CMD_OFF) begin
                busy_n = 1'b1;
                pend_n = 1'b0;
            end else if (busy_n) begin
                pend_n = 1'b1;
            end
        end
    end

    // State register: soft reset aborts the task but keeps flags and command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            pend_q  <= 1'b0;
            cmd_q   <= CMD_OFF;
            flags_q <= '0;
        end else if (sw_reset) begin
            busy_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            busy_q  <= busy_n;
            pend_q  <= pend_n;
            flags_q <= flags_n;
            if (cmd_hit) cmd_q <= cmd_val;
        end
    end

    // Service summary gated by the three class enables.
    assign summary = (en_tx  & flags_q[FL_TXOK])
                   | (en_rx  & (flags_q[FL_RXOK] | flags_q[FL_DLCW]))
                   | (en_err & (|flags_q[FL_ERR_HI:FL_ERR_LO]));

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && cmd_c != CMD_OFF && !sw_reset) |=> (busy_q && !pend_q)); // R2
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_evt && !cmd_hit && !sw_reset) |=> (!busy_q && !pend_q)); // R3
    AST_DONE_WIPES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_evt && !sw_reset) |=> (flags_q[FL_ERR_HI:FL_ERR_LO] == '0)); // R3
    AST_ERR_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_hit && kind_c == EV_ERROR && !pend_q && !sw_reset) |=> busy_q); // R4
    AST_PEND_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> busy_q); // R5
    AST_CMD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_hit || sw_reset) |=> $stable(cmd_q)); // R6
    AST_SWRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (!busy_q && !pend_q && $stable(flags_q))); // R12
endmodule

// File: rtl/mbox_prio.sv
// Module mbox_prio: picks the lowest-numbered requesting mailbox.
// Assumes N < 2**IDX_W so that the all-ones code is free to mean "none".
module mbox_prio #(
    parameter int N     = 15,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] hp,
    output logic             any
);
    localparam logic [IDX_W-1:0] NONE = '1;

    // Scan from the top down so the lowest index is written last.
    always_comb begin
        hp = NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) hp = IDX_W'(i);
        end
    end

    assign any = |req;

    AST_HP_IS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (hp != NONE) |-> req[hp]); // R9
    AST_HP_NONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hp == NONE) |-> !any); // R9
endmodule

// File: rtl/mbox_gen_flags.sv
// Module mbox_gen_flags: general flags set by engine pulses, cleared by
// writing ones. Assumes a set and a clear of one bit in a cycle favour set.
module mbox_gen_flags #(
    parameter int GEN_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_reset,
    input  logic [GEN_W-1:0] gen_set,
    input  logic             gen_clr_we,
    input  logic [GEN_W-1:0] gen_clr_mask,
    output logic [GEN_W-1:0] flags_q
);
    logic [GEN_W-1:0] clr_v;

    assign clr_v = gen_clr_we ? gen_clr_mask : '0;

    // Write-one-to-clear register with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_reset) flags_q <= '0;
        else                    flags_q <= (flags_q & ~clr_v) | gen_set;
    end

    AST_GEN_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_reset) |=> ((flags_q & $past(gen_set)) == $past(gen_set))); // R11
    AST_GEN_SWRST: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (flags_q == '0)); // R12
endmodule

// File: rtl/mbox_tracker.sv
// Module mbox_tracker: bank of mailbox slots, priority selection, general
// flags and the combined poll/interrupt output.
// Assumes one command, one flag write and one engine event per cycle at most.
module mbox_tracker
    import mbox_pkg::*;
#(
    parameter int NUM_MB = 15,
    parameter int GEN_W  = 2,
    parameter int IDX_W  = $clog2(NUM_MB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_reset,
    input  logic              cmd_we,
    input  logic [IDX_W-1:0]  cmd_sel,
    input  logic [1:0]        cmd_val,
    input  logic              flag_we,
    input  logic [IDX_W-1:0]  flag_sel,
    input  logic [FLAG_W-1:0] flag_wdata,
    input  logic              eng_valid,
    input  logic [IDX_W-1:0]  eng_sel,
    input  logic [1:0]        eng_kind,
    input  logic              eng_dlcw,
    input  logic [ERR_W-1:0]  eng_err,
    input  logic [GEN_W-1:0]  gen_set,
    input  logic              gen_clr_we,
    input  logic [GEN_W-1:0]  gen_clr_mask,
    input  logic              en_tx,
    input  logic              en_rx,
    input  logic              en_err,
    input  logic              irq_en,
    input  logic [NUM_MB-1:0] mb_ie,
    input  logic [IDX_W-1:0]  rd_sel,
    output logic [1:0]        rd_cmd,
    output logic [FLAG_W-1:0] rd_flags,
    output logic [NUM_MB-1:0] mb_busy,
    output logic [NUM_MB-1:0] mb_pend,
    output logic [NUM_MB-1:0] mb_summary,
    output logic [IDX_W-1:0]  hp_idx,
    output logic [GEN_W-1:0]  gen_flags,
    output logic              poll_flag,
    output logic              irq
);
    logic [1:0]        cmd_arr  [NUM_MB];
    logic [FLAG_W-1:0] flag_arr [NUM_MB];
    logic [NUM_MB-1:0] req;
    logic              any_req;

    for (genvar g = 0; g < NUM_MB; g++) begin : g_slot
        mbox_slot #(.IDX_W(IDX_W), .IDX(g)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .sw_reset   (sw_reset),
            .cmd_we     (cmd_we),
            .cmd_sel    (cmd_sel),
            .cmd_val    (cmd_val),
            .flag_we    (flag_we),
            .flag_sel   (flag_sel),
            .flag_wdata (flag_wdata),
            .eng_valid  (eng_valid),
            .eng_sel    (eng_sel),
            .eng_kind   (eng_kind),
            .eng_dlcw   (eng_dlcw),
            .eng_err    (eng_err),
            .en_tx      (en_tx),
            .en_rx      (en_rx),
            .en_err     (en_err),
            .busy_q     (mb_busy[g]),
            .pend_q     (mb_pend[g]),
            .cmd_q      (cmd_arr[g]),
            .flags_q    (flag_arr[g]),
            .summary    (mb_summary[g])
        );
    end

    assign req = mb_summary & mb_ie;

    mbox_prio #(.N(NUM_MB), .IDX_W(IDX_W)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .hp    (hp_idx),
        .any   (any_req)
    );

    mbox_gen_flags #(.GEN_W(GEN_W)) u_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_reset     (sw_reset),
        .gen_set      (gen_set),
        .gen_clr_we   (gen_clr_we),
        .gen_clr_mask (gen_clr_mask),
        .flags_q      (gen_flags)
    );

    // Readback mux for the selected mailbox; out-of-range reads zero.
    always_comb begin
        rd_cmd   = '0;
        rd_flags = '0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (rd_sel == IDX_W'(i)) begin
                rd_cmd   = cmd_arr[i];
                rd_flags = flag_arr[i];
            end
        end
    end

    assign poll_flag = any_req | (|gen_flags);
    assign irq       = poll_flag & irq_en;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && poll_flag)); // R10
endmodule

// File: tb/mbox_tracker_test.sv
`timescale 1ns/1ps
module mbox_tracker_test;
    localparam int N = 15;

    logic       clk = 1'b0;
    logic       rst_n, sw_reset, cmd_we, flag_we, eng_valid, eng_dlcw;
    logic [3:0] cmd_sel, flag_sel, eng_sel, rd_sel;
    logic [1:0] cmd_val, eng_kind, eng_err, gen_set, gen_clr_mask;
    logic [4:0] flag_wdata;
    logic       gen_clr_we, en_tx, en_rx, en_err, irq_en;
    logic [N-1:0] mb_ie;
    logic [1:0] rd_cmd;
    logic [4:0] rd_flags;
    logic [N-1:0] mb_busy, mb_pend, mb_summary;
    logic [3:0] hp_idx;
    logic [1:0] gen_flags;
    logic       poll_flag, irq;

    int tests = 0;
    int fails = 0;

    // behavioural reference state
    bit       m_busy [N];
    bit       m_pend [N];
    int       m_cmd  [N];
    bit [4:0] m_flag [N];
    bit [1:0] m_gen;

    always #2.5 clk = ~clk;

    mbox_tracker uut (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
        .cmd_we(cmd_we), .cmd_sel(cmd_sel), .cmd_val(cmd_val),
        .flag_we(flag_we), .flag_sel(flag_sel), .flag_wdata(flag_wdata),
        .eng_valid(eng_valid), .eng_sel(eng_sel), .eng_kind(eng_kind),
        .eng_dlcw(eng_dlcw), .eng_err(eng_err),
        .gen_set(gen_set), .gen_clr_we(gen_clr_we), .gen_clr_mask(gen_clr_mask),
        .en_tx(en_tx), .en_rx(en_rx), .en_err(en_err), .irq_en(irq_en),
        .mb_ie(mb_ie), .rd_sel(rd_sel), .rd_cmd(rd_cmd), .rd_flags(rd_flags),
        .mb_busy(mb_busy), .mb_pend(mb_pend), .mb_summary(mb_summary),
        .hp_idx(hp_idx), .gen_flags(gen_flags), .poll_flag(poll_flag), .irq(irq)
    );

    // Reference update at each edge, from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_busy[i] = 0; m_pend[i] = 0; m_cmd[i] = 0; m_flag[i] = 0;
            end
            m_gen = 0;
        end else if (sw_reset) begin
            for (int i = 0; i < N; i++) begin
                m_busy[i] = 0; m_pend[i] = 0;
            end
            m_gen = 0;
        end else begin
            for (int i = 0; i < N; i++) begin
                bit [4:0] f;
                bit b, p;
                f = (flag_we && flag_sel == i) ? (m_flag[i] & flag_wdata) : m_flag[i];
                b = m_busy[i];
                p = m_pend[i];
                if (eng_valid && eng_sel == i && m_busy[i]) begin
                    if (eng_kind == 0) begin
                        f[0] = 1; f[4:3] = 0; b = 0; p = 0;
                    end else if (eng_kind == 1) begin
                        f[1] = 1; if (eng_dlcw) f[2] = 1; f[4:3] = 0; b = 0; p = 0;
                    end else if (eng_kind == 2) begin
                        f[4:3] = f[4:3] | eng_err;
                        if (p) begin b = 0; p = 0; end
                    end else if (p) begin
                        b = 0; p = 0;
                    end
                end
                if (cmd_we && cmd_sel == i && cmd_val != 2'b11) begin
                    m_cmd[i] = cmd_val;
                    if (cmd_val != 0) begin b = 1; p = 0; end
                    else if (b) p = 1;
                end
                m_flag[i] = f; m_busy[i] = b; m_pend[i] = p;
            end
            m_gen = (m_gen & ~(gen_clr_we ? gen_clr_mask : 2'b00)) | gen_set;
        end
    end

    function automatic bit exp_sum(int i);
        return (en_tx && m_flag[i][0]) || (en_rx && (m_flag[i][1] || m_flag[i][2]))
            || (en_err && (m_flag[i][3] || m_flag[i][4]));
    endfunction

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the reference.
    task automatic compare_all();
        int hp;
        bit any;
        hp = 15; any = 0;
        for (int i = 0; i < N; i++) begin
            chk("R2/R3/R4 busy", int'(mb_busy[i]), int'(m_busy[i]));
            chk("R5 pend", int'(mb_pend[i]), int'(m_pend[i]));
            chk("R8 summary", int'(mb_summary[i]), int'(exp_sum(i)));
            if (exp_sum(i) && mb_ie[i]) begin
                any = 1;
                if (hp == 15) hp = i;
            end
        end
        chk("R9 hp_idx", int'(hp_idx), hp);
        chk("R10 poll_flag", int'(poll_flag), int'(any || m_gen != 0));
        chk("R10 irq", int'(irq), int'((any || m_gen != 0) && irq_en));
        chk("R11 gen_flags", int'(gen_flags), int'(m_gen));
        chk("R6 rd_cmd", int'(rd_cmd), rd_sel < N ? m_cmd[rd_sel] : 0);
        chk("R7 rd_flags", int'(rd_flags), rd_sel < N ? int'(m_flag[rd_sel]) : 0);
    endtask

    task automatic quiet();
        sw_reset = 0; cmd_we = 0; flag_we = 0; eng_valid = 0; eng_dlcw = 0;
        eng_err = 0; gen_set = 0; gen_clr_we = 0; gen_clr_mask = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
        quiet();
    endtask

    task automatic do_cmd(int s, int v);
        cmd_we = 1; cmd_sel = 4'(s); cmd_val = 2'(v);
    endtask

    task automatic do_eng(int s, int k, bit dl, int e);
        eng_valid = 1; eng_sel = 4'(s); eng_kind = 2'(k); eng_dlcw = dl; eng_err = 2'(e);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        quiet();
        rst_n = 0; cmd_sel = 0; cmd_val = 0; flag_sel = 0; flag_wdata = 0;
        eng_sel = 0; eng_kind = 0; rd_sel = 0;
        en_tx = 1; en_rx = 1; en_err = 1; irq_en = 1; mb_ie = '1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", int'(mb_busy), 0);
        chk("R1 pend", int'(mb_pend), 0);
        chk("R1 hp_idx", int'(hp_idx), 15);
        chk("R1 poll", int'(poll_flag), 0);
        chk("R1 gen", int'(gen_flags), 0);
        chk("R1 rd_flags", int'(rd_flags), 0);
        rst_n = 1;
        tick();
        // R2/R3: transmit on 3, then done
        rd_sel = 3; do_cmd(3, 1); tick(); tick();
        do_eng(3, 0, 0, 0); tick(); tick();
        // R2: reserved command ignored
        do_cmd(3, 3); tick();
        // R4/R5: receive on 5, error keeps busy, disable pends, release frees
        rd_sel = 5; do_cmd(5, 2); tick();
        do_eng(5, 2, 0, 2); tick();
        do_cmd(5, 0); tick(); tick();
        do_eng(5, 3, 0, 0); tick();
        // R5: disable on idle mailbox 2
        do_cmd(2, 0); tick();
        // R3: rx done with length warning clears errors
        do_cmd(5, 2); tick();
        do_eng(5, 1, 1, 0); tick();
        // R7: flag clear collides with engine set on the same mailbox
        do_cmd(7, 2); tick();
        rd_sel = 7; do_eng(7, 2, 0, 1); flag_we = 1; flag_sel = 7; flag_wdata = 5'b00000; tick();
        // R2 vs R3: new command collides with completion
        do_eng(7, 1, 0, 0); do_cmd(7, 1); tick();
        // R9: priority with masked interrupt enable
        mb_ie = 15'h7FF7; tick();
        en_tx = 0; tick(); en_tx = 1; en_rx = 0; en_err = 0; tick();
        en_rx = 1; en_err = 1; irq_en = 0; tick(); irq_en = 1;
        // R11: general set and clear collide
        gen_set = 2'b01; tick();
        gen_set = 2'b01; gen_clr_we = 1; gen_clr_mask = 2'b11; tick();
        gen_clr_we = 1; gen_clr_mask = 2'b01; tick();
        // R12: soft reset with a busy mailbox and same-cycle traffic
        do_cmd(9, 1); gen_set = 2'b10; tick();
        sw_reset = 1; do_eng(9, 0, 0, 0); do_cmd(4, 2); tick();
        // Event on idle mailbox and out-of-range index (R3)
        do_eng(9, 0, 0, 0); tick(); do_eng(15, 1, 1, 0); tick();
        // Random traffic with narrow index ranges
        for (int c = 0; c < 6000; c++) begin
            int r;
            r = $urandom % 100;
            if (r < 35) do_cmd($urandom % 6, $urandom % 4);
            if ($urandom % 100 < 40) do_eng($urandom % 7, $urandom % 4, 1'($urandom), $urandom % 4);
            if ($urandom % 100 < 25) begin
                flag_we = 1; flag_sel = 4'($urandom % 6); flag_wdata = 5'($urandom);
            end
            if ($urandom % 100 < 10) gen_set = 2'($urandom);
            if ($urandom % 100 < 10) begin gen_clr_we = 1; gen_clr_mask = 2'($urandom); end
            if ($urandom % 100 < 1) sw_reset = 1;
            if ($urandom % 100 < 3) begin
                en_tx = 1'($urandom); en_rx = 1'($urandom); en_err = 1'($urandom);
                irq_en = 1'($urandom); mb_ie = 15'($urandom);
            end
            rd_sel = 4'($urandom % 16);
            tick();
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule